// File: doc/BRIEF.md
# Two-Rate Three-Color Token Policer

This block meters a single stream of packet descriptors against one bandwidth profile and marks each packet green, yellow or red. It keeps two token buckets: a committed bucket and an optional peak bucket. A bucket refills at a programmed rate, written as an 8-bit mantissa and a 5-bit exponent. Refill happens once every 2 µs time unit, stretched by a power-of-two divider. A bucket never grows past its own programmed burst limit. Tokens are held with 8 fractional bits, so a cost of 1/256 token is represented exactly.

Each packet has a token cost. The cost is built from its length minus a programmed offset, plus a signed per-packet adjust term. A length-mode bit removes the length part, which turns the meter into a packet-rate limiter. The packet is green if the committed bucket covers the cost. Failing that, it is yellow if the peak bucket covers it. Otherwise it is red. A programmable 2-bit action for each color turns that color into a pass or drop result. The result appears one cycle after the descriptor.

Software programs the profile through a simple write-only register port. The 2 µs time base comes from the parameter CYC_PER_US, the number of clock cycles per microsecond.

Top module: `tr3c_policer`

## Requirements
- R1: A 2 µs tick occurs every 2*CYC_PER_US cycles. A refill occurs on a tick when a tick counter, reset to 0, has reached 2^rdiv − 1; the counter then returns to 0, and on any other tick it increments. A refill adds (256 + mantissa) << exponent to a bucket, counted in 1/256-token units.
- R2: After a refill a bucket holds no more than its burst limit, (256 + burst_mantissa) << burst_exponent units.
- R3: An exponent of 24 or more makes that rate or burst term zero. A bucket with a zero burst limit holds nothing after its next refill, and it covers no packet.
- R4: With length mode off, the cost in 1/256 units is 256*(length − offset) + (adjust_mantissa − 256) * 2^adjust_exponent. Offset, length and the adjust term are signed here, and any result below 1 is raised to 1.
- R5: With length mode on, the length part of the cost is zero. With adjust exponent 1 and adjust mantissa 384, every packet therefore costs exactly one token (256 units).
- R6: If cost ≤ committed level, the packet is green and the committed bucket is debited. Otherwise, if the peak bucket is enabled and cost ≤ peak level, the packet is yellow and the peak bucket is debited. Otherwise the packet is red and no bucket changes. Colors are encoded green=0, yellow=1, red=2.
- R7: Only algorithm value 2 consults the peak bucket. With any other value a packet is only green or red.
- R8: Each color has a 2-bit action. Code 01 drops the packet and every other code passes it. After reset the actions are green 00, yellow 00 and red 01.
- R9: res_valid is high exactly in the cycle after a cycle with pkt_valid high. res_color and res_drop belong to that packet.
- R10: When a refill and a packet fall in the same cycle, the refill is applied first and the cost is compared against the refilled level.
- R11: After reset both buckets are empty and all four exponents are 24 with mantissa 0. The other reset values are: rdiv 0, algorithm 2, length mode off, offset 0, adjust exponent 0, adjust mantissa 256. res_valid is low.
- R12: Register writes take effect from the next cycle. The layout is:
  - Address 0 (committed rate), 1 (committed burst), 2 (peak rate) and 3 (peak burst) each hold the exponent in [4:0] and the mantissa in [15:8].
  - Address 4 (mode) holds rdiv in [3:0], the algorithm in [5:4], length mode in [6] and the length offset in [23:16].
  - Address 5 holds the adjust exponent in [4:0] and the adjust mantissa in [16:8].
  - Address 6 holds the green action in [1:0], the yellow action in [3:2] and the red action in [7:6].
  - Writes to address 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 24 | Register write data |
| pkt_valid | input | 1 | Packet descriptor valid |
| pkt_len | input | LEN_W | Packet length in bytes |
| res_valid | output | 1 | Result valid, one cycle after pkt_valid |
| res_color | output | 2 | Color: 0 green, 1 yellow, 2 red |
| res_drop | output | 1 | Drop decision from that color's action |

## Verification
The bench builds the block with CYC_PER_US=2, so a refill comes every four cycles at rdiv 0, or every eight at rdiv 1. At that pace, buckets fill to their burst limits, drain, and refill in the same cycle as packets within a few hundred cycles. The bench keeps HAS_PEAK=1 and LEN_W=16, so the yellow path and offsets that push the cost below zero are both exercised. The exponent extremes of 22 and 23, the disabling value 24, and packet-rate mode are each reached in short phases.

// File: rtl/tr3c_pkg.sv
package tr3c_pkg;
   localparam int unsigned TOK_W   = 34;
   localparam int unsigned EXP_W   = 5;
   localparam int unsigned MAN_W   = 8;
   localparam int unsigned ADJM_W  = 9;
   localparam int unsigned OFF_W   = 8;
   localparam int unsigned RDIV_W  = 4;
   localparam int unsigned COST_W  = 48;
   localparam int unsigned CFG_W   = 24;
   localparam int unsigned OFF_EXP = 24;

   typedef enum logic [1:0] {
      CLR_GREEN  = 2'd0,
      CLR_YELLOW = 2'd1,
      CLR_RED    = 2'd2
   } color_e;

   localparam logic [1:0] ACT_DROP = 2'b01;
   localparam logic [1:0] ALG_TWO_RATE = 2'd2;

   typedef struct packed {
      logic [EXP_W-1:0]  cr_e;
      logic [MAN_W-1:0]  cr_m;
      logic [EXP_W-1:0]  cb_e;
      logic [MAN_W-1:0]  cb_m;
      logic [EXP_W-1:0]  pr_e;
      logic [MAN_W-1:0]  pr_m;
      logic [EXP_W-1:0]  pb_e;
      logic [MAN_W-1:0]  pb_m;
      logic [RDIV_W-1:0] rdiv;
      logic [1:0]        algo;
      logic              lmode;
      logic [OFF_W-1:0]  len_off;
      logic [EXP_W-1:0]  adj_e;
      logic [ADJM_W-1:0] adj_m;
      logic [1:0]        act_g;
      logic [1:0]        act_y;
      logic [1:0]        act_r;
   } prof_t;

   function automatic logic [TOK_W-1:0] tok_amount(input logic [EXP_W-1:0] e,
                                                   input logic [MAN_W-1:0] m);
      if (e >= EXP_W'(OFF_EXP)) return '0;
      return TOK_W'({1'b1, m}) << e;
   endfunction
endpackage

// File: rtl/tr3c_cfg.sv
module tr3c_cfg
   import tr3c_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       addr,
   input  logic [CFG_W-1:0] wdata,
   output prof_t            prof
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prof.cr_e    <= EXP_W'(OFF_EXP);
         prof.cr_m    <= '0;
         prof.cb_e    <= EXP_W'(OFF_EXP);
         prof.cb_m    <= '0;
         prof.pr_e    <= EXP_W'(OFF_EXP);
         prof.pr_m    <= '0;
         prof.pb_e    <= EXP_W'(OFF_EXP);
         prof.pb_m    <= '0;
         prof.rdiv    <= '0;
         prof.algo    <= ALG_TWO_RATE;
         prof.lmode   <= 1'b0;
         prof.len_off <= '0;
         prof.adj_e   <= '0;
         prof.adj_m   <= ADJM_W'(256);
         prof.act_g   <= 2'b00;
         prof.act_y   <= 2'b00;
         prof.act_r   <= ACT_DROP;
      end else if (we) begin
         case (addr)
            3'd0: begin prof.cr_e <= wdata[4:0]; prof.cr_m <= wdata[15:8]; end
            3'd1: begin prof.cb_e <= wdata[4:0]; prof.cb_m <= wdata[15:8]; end
            3'd2: begin prof.pr_e <= wdata[4:0]; prof.pr_m <= wdata[15:8]; end
            3'd3: begin prof.pb_e <= wdata[4:0]; prof.pb_m <= wdata[15:8]; end
            3'd4: begin
               prof.rdiv    <= wdata[3:0];
               prof.algo    <= wdata[5:4];
               prof.lmode   <= wdata[6];
               prof.len_off <= wdata[23:16];
            end
            3'd5: begin prof.adj_e <= wdata[4:0]; prof.adj_m <= wdata[16:8]; end
            3'd6: begin
               prof.act_g <= wdata[1:0];
               prof.act_y <= wdata[3:2];
               prof.act_r <= wdata[7:6];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tr3c_tick.sv
module tr3c_tick
   import tr3c_pkg::*;
#(
   parameter int unsigned CYC_PER_US = 125,
   parameter int unsigned DIV_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RDIV_W-1:0] rdiv,
   output logic              refill
);
   localparam int unsigned TICK_CYC = 2 * CYC_PER_US;
   localparam int unsigned CNT_W    = $clog2(TICK_CYC);

   if (CYC_PER_US < 1) begin : g_bad_cyc
      $error("CYC_PER_US must be at least 1");
   end
   if (DIV_W < 16) begin : g_bad_div
      $error("DIV_W must hold 2^15");
   end

   logic [CNT_W-1:0] us_cnt;
   logic [DIV_W-1:0] div_cnt;
   logic [DIV_W-1:0] div_lim;
   logic             tick;

   assign tick    = (us_cnt == CNT_W'(TICK_CYC - 1));
   assign div_lim = (DIV_W'(1) << rdiv) - DIV_W'(1);
   assign refill  = tick && (div_cnt >= div_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         us_cnt  <= '0;
         div_cnt <= '0;
      end else begin
         us_cnt <= tick ? '0 : us_cnt + CNT_W'(1);
         if (tick) div_cnt <= refill ? '0 : div_cnt + DIV_W'(1);
      end
   end

   // R1
   refill_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refill |=> !refill);
endmodule

// File: rtl/tr3c_bucket.sv
module tr3c_bucket
   import tr3c_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             refill,
   input  logic [EXP_W-1:0] rate_e,
   input  logic [MAN_W-1:0] rate_m,
   input  logic [EXP_W-1:0] burst_e,
   input  logic [MAN_W-1:0] burst_m,
   input  logic             debit,
   input  logic [TOK_W-1:0] cost,
   output logic [TOK_W-1:0] avail
);
   logic [TOK_W-1:0] level;
   logic [TOK_W-1:0] lim;
   logic [TOK_W:0]   sum;

   assign lim   = tok_amount(burst_e, burst_m);
   assign sum   = {1'b0, level} + {1'b0, tok_amount(rate_e, rate_m)};
   assign avail = !refill ? level :
                  (sum > {1'b0, lim}) ? lim : sum[TOK_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) level <= '0;
      else        level <= debit ? avail - cost : avail;
   end

   // R2
   burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refill |=> level <= $past(lim));
   // R6
   debit_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debit |-> cost <= avail);
endmodule

// File: rtl/tr3c_cost.sv
module tr3c_cost
   import tr3c_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic [LEN_W-1:0]  len,
   input  logic              lmode,
   input  logic [OFF_W-1:0]  len_off,
   input  logic [EXP_W-1:0]  adj_e,
   input  logic [ADJM_W-1:0] adj_m,
   output logic [COST_W-1:0] cost
);
   if (LEN_W + 10 > COST_W) begin : g_bad_len
      $error("LEN_W too wide for cost arithmetic");
   end

   logic signed [COST_W-1:0] len_s, off_s, byte_s, adjm_s, adj_s, raw_s;

   always_comb begin
      len_s  = signed'(COST_W'(len));
      off_s  = signed'(COST_W'(len_off));
      byte_s = lmode ? '0 : ((len_s - off_s) <<< 8);
      adjm_s = signed'(COST_W'(adj_m)) - signed'(COST_W'(256));
      adj_s  = adjm_s <<< adj_e;
      raw_s  = byte_s + adj_s;
      cost   = (raw_s < signed'(COST_W'(1))) ? COST_W'(1) : COST_W'(raw_s);
   end
endmodule

// File: rtl/tr3c_policer.sv
module tr3c_policer
   import tr3c_pkg::*;
#(
   parameter int unsigned CYC_PER_US = 125,
   parameter int unsigned LEN_W      = 16,
   parameter bit          HAS_PEAK   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             pkt_valid,
   input  logic [LEN_W-1:0] pkt_len,
   output logic             res_valid,
   output logic [1:0]       res_color,
   output logic             res_drop
);
   if (COST_W <= TOK_W) begin : g_bad_tok
      $error("cost width must exceed token width");
   end

   prof_t             prof;
   logic              refill;
   logic [COST_W-1:0] cost;
   logic [TOK_W-1:0]  c_avail, p_avail;
   logic              c_ok, p_ok, c_debit, p_debit, two_rate;
   color_e            color;
   logic [1:0]        act;

   tr3c_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .prof(prof)
   );

   tr3c_tick #(.CYC_PER_US(CYC_PER_US), .DIV_W(16)) u_tick (
      .clk(clk), .rst_n(rst_n), .rdiv(prof.rdiv), .refill(refill)
   );

   tr3c_cost #(.LEN_W(LEN_W)) u_cost (
      .len(pkt_len), .lmode(prof.lmode), .len_off(prof.len_off),
      .adj_e(prof.adj_e), .adj_m(prof.adj_m), .cost(cost)
   );

   tr3c_bucket u_commit (
      .clk(clk), .rst_n(rst_n), .refill(refill),
      .rate_e(prof.cr_e), .rate_m(prof.cr_m),
      .burst_e(prof.cb_e), .burst_m(prof.cb_m),
      .debit(c_debit), .cost(cost[TOK_W-1:0]), .avail(c_avail)
   );

   if (HAS_PEAK) begin : g_peak
      tr3c_bucket u_peak (
         .clk(clk), .rst_n(rst_n), .refill(refill),
         .rate_e(prof.pr_e), .rate_m(prof.pr_m),
         .burst_e(prof.pb_e), .burst_m(prof.pb_m),
         .debit(p_debit), .cost(cost[TOK_W-1:0]), .avail(p_avail)
      );
   end else begin : g_no_peak
      assign p_avail = '0;
   end

   assign two_rate = (prof.algo == ALG_TWO_RATE);
   assign c_ok     = cost <= COST_W'(c_avail);
   assign p_ok     = two_rate && (cost <= COST_W'(p_avail));
   assign c_debit  = pkt_valid && c_ok;
   assign p_debit  = pkt_valid && !c_ok && p_ok;

   always_comb begin
      if (c_ok) begin
         color = CLR_GREEN;  act = prof.act_g;
      end else if (p_ok) begin
         color = CLR_YELLOW; act = prof.act_y;
      end else begin
         color = CLR_RED;    act = prof.act_r;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_color <= 2'd0;
         res_drop  <= 1'b0;
      end else begin
         res_valid <= pkt_valid;
         if (pkt_valid) begin
            res_color <= color;
            res_drop  <= (act == ACT_DROP);
         end
      end
   end

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> res_valid);
   // R9
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_valid |=> !res_valid);
   // R6
   single_debit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(c_debit && p_debit));
   // R7
   no_yellow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !two_rate) |=> res_color != CLR_YELLOW);
   // R6
   color_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_color != 2'd3);
endmodule

// File: tb/tr3c_policer_tb.sv
module tr3c_policer_tb;
   localparam int CPU  = 2;
   localparam int TICK = 2 * CPU;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [23:0] cfg_wdata = '0;
   logic        pkt_valid = 1'b0;
   logic [15:0] pkt_len = '0;
   logic        res_valid;
   logic [1:0]  res_color;
   logic        res_drop;

   int errors = 0;
   int checks = 0;
   string cur_req = "R11";
   bit done = 0;

   always #4 clk = ~clk;

   tr3c_policer #(.CYC_PER_US(CPU), .LEN_W(16), .HAS_PEAK(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
      .res_valid(res_valid), .res_color(res_color), .res_drop(res_drop)
   );

   // behavioural reference state
   longint c_lv, p_lv;
   int us_c, dv_c;
   int m_e[4], m_m[4];
   int m_rdiv, m_algo, m_lmode, m_off, m_adje, m_adjm, m_ag, m_ay, m_ar;
   bit e_valid;
   int e_color;
   bit e_drop;

   function automatic longint amt(int e, int m);
      if (e >= 24) return 0;
      return longint'(256 + m) << e;
   endfunction

   task automatic model_reset();
      c_lv = 0; p_lv = 0; us_c = 0; dv_c = 0;
      for (int i = 0; i < 4; i++) begin m_e[i] = 24; m_m[i] = 0; end
      m_rdiv = 0; m_algo = 2; m_lmode = 0; m_off = 0; m_adje = 0; m_adjm = 256;
      m_ag = 0; m_ay = 0; m_ar = 1;
      e_valid = 0; e_color = 0; e_drop = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit tick, rf;
         longint c_av, p_av, cost, lim;
         int act;
         tick = (us_c == TICK - 1);
         us_c = tick ? 0 : us_c + 1;
         rf = tick && (dv_c >= (1 << m_rdiv) - 1);
         if (tick) dv_c = rf ? 0 : dv_c + 1;
         c_av = c_lv; p_av = p_lv;
         if (rf) begin
            lim = amt(m_e[1], m_m[1]);
            c_av = c_lv + amt(m_e[0], m_m[0]); if (c_av > lim) c_av = lim;
            lim = amt(m_e[3], m_m[3]);
            p_av = p_lv + amt(m_e[2], m_m[2]); if (p_av > lim) p_av = lim;
         end
         e_valid = pkt_valid;
         if (pkt_valid) begin
            cost = (m_lmode ? 0 : (longint'(pkt_len) - m_off) * 256)
                 + (longint'(m_adjm) - 256) * (longint'(1) << m_adje);
            if (cost < 1) cost = 1;
            if (cost <= c_av) begin
               e_color = 0; act = m_ag; c_av -= cost;
            end else if (m_algo == 2 && cost <= p_av) begin
               e_color = 1; act = m_ay; p_av -= cost;
            end else begin
               e_color = 2; act = m_ar;
            end
            e_drop = (act == 1);
         end
         c_lv = c_av; p_lv = p_av;
         if (cfg_we) begin
            case (cfg_addr)
               0, 1, 2, 3: begin
                  m_e[cfg_addr] = int'(cfg_wdata[4:0]);
                  m_m[cfg_addr] = int'(cfg_wdata[15:8]);
               end
               4: begin
                  m_rdiv = int'(cfg_wdata[3:0]); m_algo = int'(cfg_wdata[5:4]);
                  m_lmode = int'(cfg_wdata[6]); m_off = int'(cfg_wdata[23:16]);
               end
               5: begin m_adje = int'(cfg_wdata[4:0]); m_adjm = int'(cfg_wdata[16:8]); end
               6: begin
                  m_ag = int'(cfg_wdata[1:0]); m_ay = int'(cfg_wdata[3:2]);
                  m_ar = int'(cfg_wdata[7:6]);
               end
               default: ;
            endcase
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         checks++;
         if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s reset: res_valid=%0b expected 0", "R11", res_valid);
         end
      end else if (!done) begin
         checks++;
         if (res_valid !== e_valid) begin
            errors++;
            $display("FAIL %s R9 res_valid=%0b expected %0b", cur_req, res_valid, e_valid);
         end else if (e_valid) begin
            checks++;
            if (res_color !== 2'(e_color) || res_drop !== e_drop) begin
               errors++;
               $display("FAIL %s color=%0d drop=%0b expected color=%0d drop=%0b",
                        cur_req, res_color, res_drop, e_color, e_drop);
            end
         end
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 24'(d); pkt_valid = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pkt_valid = 1'b0;
      end
   endtask

   task automatic pkts(input int n, input int lo, input int hi, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pkt_valid = 1'b1; pkt_len = 16'($urandom_range(hi, lo));
         if (gap > 0 && $urandom_range(gap, 0) == 0) begin
            @(negedge clk);
            pkt_valid = 1'b0;
         end
      end
      @(negedge clk);
      pkt_valid = 1'b0;
   endtask

   function automatic int rw(int e, int m); return (m << 8) | e; endfunction
   function automatic int mw(int rdiv, int algo, int lm, int off);
      return rdiv | (algo << 4) | (lm << 6) | (off << 16);
   endfunction

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R3";              // disabled buckets at reset: red, dropped (R8)
      pkts(4, 40, 80, 0);
      idle(20);
      pkts(3, 1, 10, 0);

      cur_req = "R1";              // 16 tokens per refill, rdiv 1
      wr(0, rw(4, 0));
      wr(1, rw(8, 0));
      wr(4, mw(1, 2, 0, 0));
      idle(40);
      pkts(10, 10, 30, 2);
      cur_req = "R2";              // saturate at 256 tokens
      idle(300);
      pkts(30, 20, 120, 0);
      cur_req = "R10";             // steady traffic crossing refill cycles
      pkts(80, 1, 20, 1);

      cur_req = "R6";              // peak bucket brings yellow
      wr(2, rw(3, 128));
      wr(3, rw(7, 64));
      idle(200);
      pkts(60, 30, 90, 1);
      pkts(60, 5, 40, 3);

      cur_req = "R7";              // other algorithm: no yellow
      wr(4, mw(1, 0, 0, 0));
      idle(100);
      pkts(50, 20, 90, 1);
      wr(4, mw(1, 3, 0, 0));
      pkts(20, 20, 90, 0);

      cur_req = "R4";              // offset and adjust, clamp at 1/256
      wr(4, mw(0, 2, 0, 20));
      wr(5, rw(2, 300) | 0);
      wr(5, (300 << 8) | 2);
      idle(50);
      pkts(60, 0, 60, 1);
      wr(5, (0 << 8) | 8);
      pkts(30, 0, 200, 0);

      cur_req = "R5";              // packet-rate metering
      wr(5, (384 << 8) | 1);
      wr(4, mw(0, 2, 1, 0));
      wr(0, rw(0, 0));
      wr(1, rw(3, 0));
      wr(2, rw(24, 0));
      wr(3, rw(24, 0));
      idle(60);
      pkts(40, 100, 1500, 0);

      cur_req = "R8";              // action codes per color
      wr(6, 1 | (1 << 2) | (2 << 6));
      idle(20);
      pkts(20, 1, 100, 1);
      wr(6, 3 | (0 << 2) | (0 << 6));
      pkts(20, 1, 100, 1);

      cur_req = "R12";             // address 7 ignored, large exponents
      wr(7, 24'hffffff);
      pkts(10, 1, 100, 0);
      wr(5, (256 << 8) | 0);
      wr(4, mw(2, 2, 0, 0));
      wr(0, rw(22, 255));
      wr(1, rw(23, 255));
      wr(2, rw(5, 7));
      wr(3, rw(22, 3));
      idle(40);
      pkts(40, 1000, 65535, 1);

      cur_req = "R3";              // disable committed bucket after use
      wr(0, rw(24, 0));
      wr(1, rw(24, 0));
      idle(40);
      pkts(20, 1, 50, 0);

      idle(3);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule